// File: doc/BRIEF.md
# External Memory Chip-Select Decoder

This block turns a 22-bit word address into one of five active-low chip selects for external memory: a ROM select, three bank selects (bank 1 to bank 3) and a RAM select. Word addresses below 0x4000 belong to on-chip resources, and no external select is driven for them. A single configuration register sets how the space is split. A RAM window of programmable size sits at the very top of the address space and wins over the ROM layout wherever the two overlap. The ROM side gives the whole external range to the ROM select, or splits it into two halves, or splits it into four 1-megaword quarters.

Each access request is decoded on the clock edge where it is sampled. The selected line is held low for the following cycle only. The same request loads a wait-state count from the configuration register. A ready output stays low for that many cycles and then returns high. Bus arbitration and memory timing belong to other blocks.

Top module: `extmem_cs_decoder`

## Requirements
- R1: After reset the configuration is zero. No select is low, `wait_ready` is high, and an access to any address at or above 0x4000 drives the ROM select.
- R2: An access with a word address below 0x4000 drives no select low, whatever the configuration.
- R3: With ROM mode (config bits 7:6) equal to 00 and no RAM hit, every address from 0x4000 to 0x3FFFFF selects ROM.
- R4: With ROM mode 01 and no RAM hit, addresses 0x4000 to 0x1FFFFF select ROM and 0x200000 to 0x3FFFFF select bank 1 (`bank_cs_n[0]`).
- R5: With ROM mode 10 or 11 and no RAM hit, address bits 21:20 pick the select. 0 picks ROM (from 0x4000), 1 picks bank 1 (`bank_cs_n[0]`), 2 picks bank 2 (`bank_cs_n[1]`) and 3 picks bank 3 (`bank_cs_n[2]`).
- R6: When config bit 11 is 0, the RAM select is never driven, whatever bits 10:8 hold.
- R7: When config bit 11 is 1, the RAM window covers 0x400000 − (4096 << bits 10:8) up to 0x3FFFFF. The sizes run from 4 to 512 kilowords, and the word just below the window is not RAM.
- R8: An address inside an enabled RAM window selects RAM only, never a ROM or bank select.
- R9: At most one select is low in any cycle, and all are high in a cycle that follows a clock edge with no request.
- R10: After each sampled request, `wait_ready` is low for exactly N cycles and then high, where N is config bits 2:1. N = 0 keeps it high.
- R11: Selects are registered. They change only on the clock edge that samples the request and appear in the cycle after it. A configuration write takes effect for requests sampled on later edges. Bits 5:3 and 0 of the configuration have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 12 | Configuration write data |
| acc_req | input | 1 | Access request, sampled each edge |
| acc_addr | input | 22 | Word address of the access |
| rom_cs_n | output | 1 | ROM select, active low |
| bank_cs_n | output | 3 | Bank 1..3 selects, active low (index 0 = bank 1) |
| ram_cs_n | output | 1 | RAM window select, active low |
| wait_ready | output | 1 | High when the wait-state count has expired |

## Verification
A wrong field extraction or a wrong window comparison in the configuration shows up one cycle after the affected request, as the wrong select going low or as two selects low at once. The bench sweeps all 64 combinations of ROM mode and RAM code against addresses on every region and window edge, so an off-by-one boundary shows up on the first access that touches it. A wait counter that loads or counts down wrongly shows as `wait_ready` changing one cycle early or late after a single request, which the bench checks for every wait value.

// File: rtl/extmem_cs_pkg.sv
package extmem_cs_pkg;
   // configuration word layout; positions decoded by the field extraction
   localparam int CFG_W        = 12;
   localparam int RAM_EN_BIT   = 11;
   localparam int RAM_SIZE_LSB = 8;
   localparam int RAM_SIZE_W   = 3;
   localparam int ROM_MODE_LSB = 6;
   localparam int ROM_MODE_W   = 2;
   localparam int WAIT_LSB     = 1;
   localparam int WAIT_W       = 2;

   typedef struct packed {
      logic                  ram_en;
      logic [RAM_SIZE_W-1:0] ram_size;
      logic [ROM_MODE_W-1:0] rom_mode;
      logic [WAIT_W-1:0]     wait_n;
   } cfg_t;

   // active-high select vector
   typedef struct packed {
      logic       ram;
      logic [2:0] bank;
      logic       rom;
   } sel_t;

   localparam logic [ROM_MODE_W-1:0] ROM_WHOLE  = 2'b00;
   localparam logic [ROM_MODE_W-1:0] ROM_HALVES = 2'b01;
endpackage

// File: rtl/extmem_cfg_reg.sv
module extmem_cfg_reg
   import extmem_cs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg
);
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{wdata[5:3], wdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         cfg.ram_en   <= wdata[RAM_EN_BIT];
         cfg.ram_size <= wdata[RAM_SIZE_LSB +: RAM_SIZE_W];
         cfg.rom_mode <= wdata[ROM_MODE_LSB +: ROM_MODE_W];
         cfg.wait_n   <= wdata[WAIT_LSB +: WAIT_W];
      end
   end
endmodule

// File: rtl/extmem_ram_window.sv
module extmem_ram_window #(
   parameter int ADDR_W   = 22,
   parameter int MIN_LOG2 = 12,
   parameter int CODE_W   = 3,
   localparam int SLICE_W = ADDR_W - MIN_LOG2,
   localparam int N_SIZES = 1 << CODE_W
) (
   input  logic               en,
   input  logic [CODE_W-1:0]  size,
   input  logic [SLICE_W-1:0] addr_hi,
   output logic               hit
);
   generate
      if (MIN_LOG2 + N_SIZES - 1 >= ADDR_W) begin : g_bad_size
         $error("largest RAM window exceeds the address space");
      end
   endgenerate

   logic [N_SIZES-1:0] in_win;

   // window k spans the top 2**(MIN_LOG2+k) words: all upper bits set
   generate
      for (genvar k = 0; k < N_SIZES; k++) begin : g_win
         assign in_win[k] = &addr_hi[SLICE_W-1:k];
      end
   endgenerate

   assign hit = en & in_win[size];
endmodule

// File: rtl/extmem_rom_region.sv
module extmem_rom_region
   import extmem_cs_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int REGION_LOG2 = 20
) (
   input  logic [ROM_MODE_W-1:0] mode,
   input  logic [1:0]            region,
   output logic                  rom,
   output logic [2:0]            bank
);
   generate
      if (ADDR_W != REGION_LOG2 + 2) begin : g_bad_region
         $error("address space must hold exactly four regions");
      end
   endgenerate

   always_comb begin
      rom  = 1'b0;
      bank = '0;
      unique casez (mode)
         ROM_WHOLE:  rom = 1'b1;
         ROM_HALVES: begin
            if (region[1]) bank[0] = 1'b1;
            else           rom     = 1'b1;
         end
         default: begin
            if (region == 2'd0) rom = 1'b1;
            else                bank[region - 2'd1] = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/extmem_wait_timer.sv
module extmem_wait_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   output logic             ready
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wait counter needs at least one bit");
      end
   endgenerate

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= count;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign ready = (remain == '0);

   // R10: a nonzero count drops ready on the next cycle
   a_r10_wait_drop : assert property (@(posedge clk) disable iff (!rst_n)
      start && (count != '0) |=> !ready);
   // R10: with no new start, ready never falls again
   a_r10_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !start && ready |=> ready);
endmodule

// File: rtl/extmem_cs_decoder.sv
module extmem_cs_decoder
   import extmem_cs_pkg::*;
#(
   parameter int          ADDR_W      = 22,
   parameter int          RAM_MIN_LOG2 = 12,
   parameter int          REGION_LOG2 = 20,
   parameter logic [21:0] INT_LIMIT   = 22'h004000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              rom_cs_n,
   output logic [2:0]        bank_cs_n,
   output logic              ram_cs_n,
   output logic              wait_ready
);
   localparam int RAM_SLICE_W = ADDR_W - RAM_MIN_LOG2;

   generate
      if (ADDR_W != 22) begin : g_bad_addr
         $error("internal limit constant assumes a 22-bit address");
      end
   endgenerate

   cfg_t  cfg;
   logic  ram_hit;
   logic  rom_sel;
   logic [2:0] bank_sel;
   logic  external;
   sel_t  sel_next, sel_q;

   extmem_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   extmem_ram_window #(
      .ADDR_W   (ADDR_W),
      .MIN_LOG2 (RAM_MIN_LOG2),
      .CODE_W   (RAM_SIZE_W)
   ) u_ram (
      .en      (cfg.ram_en),
      .size    (cfg.ram_size),
      .addr_hi (acc_addr[ADDR_W-1:RAM_MIN_LOG2]),
      .hit     (ram_hit)
   );

   extmem_rom_region #(
      .ADDR_W      (ADDR_W),
      .REGION_LOG2 (REGION_LOG2)
   ) u_rom (
      .mode   (cfg.rom_mode),
      .region (acc_addr[ADDR_W-1:REGION_LOG2]),
      .rom    (rom_sel),
      .bank   (bank_sel)
   );

   extmem_wait_timer #(.CNT_W(WAIT_W)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_req),
      .count (cfg.wait_n),
      .ready (wait_ready)
   );

   assign external = (acc_addr >= INT_LIMIT);

   // RAM window takes precedence over any ROM-side select
   always_comb begin
      sel_next = '0;
      if (acc_req && external) begin
         if (ram_hit) begin
            sel_next.ram = 1'b1;
         end else begin
            sel_next.rom  = rom_sel;
            sel_next.bank = bank_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_next;
   end

   assign rom_cs_n  = ~sel_q.rom;
   assign bank_cs_n = ~sel_q.bank;
   assign ram_cs_n  = ~sel_q.ram;

   // R9: selects are mutually exclusive
   a_r9_one_select : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{ram_cs_n, bank_cs_n, rom_cs_n}));
   // R9: no request, no select
   a_r9_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> (&{ram_cs_n, bank_cs_n, rom_cs_n}));
   // R2: internal addresses drive nothing
   a_r2_internal : assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && (acc_addr < INT_LIMIT) |=> (&{ram_cs_n, bank_cs_n, rom_cs_n}));
   // R8: a RAM hit selects RAM
   a_r8_ram_wins : assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && external && ram_hit |=> !ram_cs_n);
   // R6: RAM disabled keeps its select high
   a_r6_ram_off : assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.ram_en |=> ram_cs_n);
   // R11: an external request always yields exactly one select
   a_r11_latency : assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && external |=> !(&{ram_cs_n, bank_cs_n, rom_cs_n}));
endmodule

// File: tb/test_extmem_cs_decoder.sv
module test_extmem_cs_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_wdata = '0;
   logic        acc_req = 1'b0;
   logic [21:0] acc_addr = '0;
   logic        rom_cs_n, ram_cs_n, wait_ready;
   logic [2:0]  bank_cs_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   extmem_cs_decoder i_extmem_cs_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .acc_req(acc_req), .acc_addr(acc_addr), .rom_cs_n(rom_cs_n),
      .bank_cs_n(bank_cs_n), .ram_cs_n(ram_cs_n), .wait_ready(wait_ready)
   );

   // observed active-high {ram, bank3, bank2, bank1, rom}
   function automatic logic [4:0] seen();
      return ~{ram_cs_n, bank_cs_n[2], bank_cs_n[1], bank_cs_n[0], rom_cs_n};
   endfunction

   function automatic logic [4:0] expect_sel(logic [11:0] c, logic [21:0] a);
      int unsigned win_base;
      if (a < 22'h4000) return 5'b0;
      win_base = 32'h400000 - (32'd4096 << c[10:8]);
      if (c[11] && (32'(a) >= win_base)) return 5'b10000;
      case (c[7:6])
         2'b00: return 5'b00001;
         2'b01: return (a >= 22'h200000) ? 5'b00010 : 5'b00001;
         default: return 5'b00001 << a[21:20];
      endcase
   endfunction

   function automatic logic [21:0] addr_at(int i);
      case (i)
         0: return 22'h000000;
         1: return 22'h003FFF;
         2: return 22'h004000;
         3: return 22'h0FFFFF;
         4: return 22'h100000;
         5: return 22'h1FFFFF;
         6: return 22'h200000;
         7: return 22'h300000;
         8: return 22'h3FFFFF;
         default: begin
            int k = (i - 9) / 2;
            logic [21:0] base = 22'(32'h400000 - (32'd4096 << k));
            return ((i % 2) == 1) ? base : base - 22'd1;
         end
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic write_cfg(logic [11:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(logic [11:0] c, logic [21:0] a);
      string tag;
      logic [4:0] e;
      e = expect_sel(c, a);
      if (a < 22'h4000)                tag = "R2";
      else if (e[4])                   tag = "R8";
      else if (c[11])                  tag = "R7";
      else if (c[10:8] != 3'd0)        tag = "R6";
      else if (c[7:6] == 2'b00)        tag = "R3";
      else if (c[7:6] == 2'b01)        tag = "R4";
      else                             tag = "R5";
      @(negedge clk);
      acc_req = 1'b1; acc_addr = a;
      @(negedge clk);
      check(tag, 32'(seen()), 32'(e));
      acc_req = 1'b0;
      @(negedge clk);
      check("R9 idle", 32'(seen()), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 selects", 32'(seen()), 32'd0);
      check("R1 ready", 32'(wait_ready), 32'd1);
      // R11: request driven, no edge yet: selects unchanged
      acc_req = 1'b1; acc_addr = 22'h123456;
      #5;
      check("R11 before edge", 32'(seen()), 32'd0);
      @(negedge clk);
      check("R1 rom after reset", 32'(seen()), 32'd1);
      acc_req = 1'b0;
      @(negedge clk);

      // sweep every ROM mode and RAM code; bits 5:3 and 0 set to show no effect (R11)
      for (int ram = 0; ram < 16; ram++) begin
         for (int rm = 0; rm < 4; rm++) begin
            logic [11:0] c = {4'(ram), 2'(rm), 3'b101, 2'b00, 1'b1};
            write_cfg(c);
            for (int i = 0; i < 25; i++) access(c, addr_at(i));
         end
      end

      // R10: wait-state count for each value
      for (int n = 0; n < 4; n++) begin
         write_cfg({4'b0, 2'b00, 3'b000, 2'(n), 1'b0});
         @(negedge clk);
         acc_req = 1'b1; acc_addr = 22'h004000;
         @(negedge clk);
         acc_req = 1'b0;
         for (int cyc = 1; cyc <= n + 1; cyc++) begin
            check($sformatf("R10 n=%0d cyc=%0d", n, cyc), 32'(wait_ready),
                  32'(cyc > n));
            @(negedge clk);
         end
      end

      // R11: config written on the same edge as a request applies only afterwards
      write_cfg(12'h000);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 12'h800;  // RAM 4K window
      acc_req = 1'b1; acc_addr = 22'h3FFFFF;
      @(negedge clk);
      check("R11 old cfg", 32'(seen()), 32'd1);
      cfg_we = 1'b0;
      @(negedge clk);
      check("R11 new cfg", 32'(seen()), 32'h10);
      acc_req = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule